// File: doc/BRIEF.md
# DMA Channel Trigger and Burst Sequencer

This block sits in front of one DMA channel and decides when the channel may move data and how many transfers each start event buys. A start event comes from one of three places. An external hardware trigger can be sensed on an edge or on a level, with either polarity. A peripheral request line can pace the channel. When neither of those is enabled, a software start pulse launches the channel.

Each start event opens a run of transfers. The run holds one transfer in single mode, or 2^N transfers in burst mode. Every transfer goes to a downstream data mover through a request/done handshake. The block counts completed transfers and pulses a flag when a run ends.

The trigger input is asynchronous and passes through a two-flop synchronizer before it is sensed. In edge mode, one trigger that arrives during a run is remembered and served afterwards. In level mode, runs repeat while the level stays active. Address generation, bus mastering and the selection of the trigger source belong to other blocks.

Top module: `dma_trig_seq`

## Requirements
- R1: After reset, `xfer_req` is low, `burst_done` is low and `xfer_count` is zero.
- R2: `xfer_req` stays high until the cycle in which `xfer_done` is sampled high. Each such handshake adds exactly one to `xfer_count`.
- R3: With `cfg_burst` set, one start event yields 2^`cfg_bpow` transfers. `cfg_bpow` is a 4-bit field: values 0 to 10 are used as given, and values above 10 act as 10, giving 1024 transfers.
- R4: With `cfg_burst` clear, one start event yields exactly one transfer.
- R5: In edge mode (`cfg_level`=0), a rising edge of `trig_in` starts a run when `cfg_pol_hi`=1 and a falling edge starts a run when `cfg_pol_hi`=0. The opposite edge starts nothing.
- R6: In level mode (`cfg_level`=1), the trigger is active when it equals `cfg_pol_hi`. A new run starts whenever the block is idle and the synchronized trigger is active, so runs repeat back to back while the level persists.
- R7: With `cfg_trig_en` clear, activity on `trig_in` starts no transfer.
- R8: In edge mode, the first active edge seen during a run is kept and starts exactly one further run after the current one. Additional edges during that run are dropped.
- R9: With `cfg_preq_en` set, a transfer request is issued only in a cycle following one in which `preq` was high. With the trigger disabled, the channel is always armed, so each single-cycle `preq` pulse yields one transfer.
- R10: `sw_start` launches a run only when both `cfg_trig_en` and `cfg_preq_en` are clear. Otherwise it has no effect.
- R11: `burst_done` pulses high for one cycle, in the cycle after the done of the final transfer of a run. It is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trig_en | input | 1 | Hardware trigger enable |
| cfg_preq_en | input | 1 | Peripheral request pacing enable |
| cfg_pol_hi | input | 1 | 1: active high / rising; 0: active low / falling |
| cfg_level | input | 1 | 1: level sensing; 0: edge sensing |
| cfg_burst | input | 1 | 1: burst of 2^cfg_bpow transfers; 0: single transfer |
| cfg_bpow | input | POW_W | Burst length exponent, clamped to MAX_POW |
| trig_in | input | 1 | Asynchronous hardware trigger |
| preq | input | 1 | Synchronous peripheral request |
| sw_start | input | 1 | Software start pulse |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_done | input | 1 | Data mover completes the current transfer |
| burst_done | output | 1 | One-cycle pulse at the end of a run |
| xfer_count | output | CNT_W | Completed transfer count, wrapping |

## Verification
The hardest case to reach is an edge trigger that lands while a run is still in flight. It needs a run long enough to overlap several trigger pulses after synchronizer delay. The bench slows the data mover to several cycles per transfer with an eight-transfer burst, then fires three more trigger pulses inside that run, and expects exactly two runs. Level repetition is pinned down the same way: the trigger is released in the very cycle the first `burst_done` appears. Because of synchronizer delay, exactly one more run must still follow.

// File: rtl/dma_trig_seq.sv
module dma_trig_seq #(
  parameter int CNT_W   = 16,
  parameter int POW_W   = 4,
  parameter int MAX_POW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_trig_en,
  input  logic             cfg_preq_en,
  input  logic             cfg_pol_hi,
  input  logic             cfg_level,
  input  logic             cfg_burst,
  input  logic [POW_W-1:0] cfg_bpow,
  input  logic             trig_in,
  input  logic             preq,
  input  logic             sw_start,
  output logic             xfer_req,
  input  logic             xfer_done,
  output logic             burst_done,
  output logic [CNT_W-1:0] xfer_count
);
  localparam int LEN_W = MAX_POW + 1;

  logic [2:0]       sync_q;
  logic             run_q, req_q, pend_q, bdone_q;
  logic [LEN_W-1:0] rem_q;
  logic [CNT_W-1:0] cnt_q;

  // trigger conditioning
  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], trig_in};
  end

  wire act_now = cfg_pol_hi ? sync_q[1] : ~sync_q[1];
  wire act_old = cfg_pol_hi ? sync_q[2] : ~sync_q[2];
  wire edge_ev = act_now & ~act_old;

  // run length
  wire [POW_W-1:0] pow_eff = (cfg_bpow > POW_W'(MAX_POW)) ? POW_W'(MAX_POW) : cfg_bpow;
  wire [LEN_W-1:0] run_len = cfg_burst ? (LEN_W'(1) << pow_eff) : LEN_W'(1);

  wire launch = cfg_trig_en ? (cfg_level ? act_now : (edge_ev | pend_q))
                            : (cfg_preq_en | sw_start);
  wire gate   = ~cfg_preq_en | preq;
  wire last   = (rem_q == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      req_q   <= 1'b0;
      pend_q  <= 1'b0;
      bdone_q <= 1'b0;
      rem_q   <= '0;
      cnt_q   <= '0;
    end else begin
      bdone_q <= 1'b0;
      if (!cfg_trig_en || cfg_level) pend_q <= 1'b0;
      if (!run_q) begin
        if (launch) begin
          run_q  <= 1'b1;
          rem_q  <= run_len;
          pend_q <= 1'b0;
        end
      end else begin
        if (cfg_trig_en && !cfg_level && edge_ev) pend_q <= 1'b1;
        if (!req_q) begin
          if (gate) req_q <= 1'b1;
        end else if (xfer_done) begin
          req_q <= 1'b0;
          cnt_q <= cnt_q + CNT_W'(1);
          rem_q <= rem_q - LEN_W'(1);
          if (last) begin
            run_q   <= 1'b0;
            bdone_q <= 1'b1;
          end
        end
      end
    end
  end

  assign xfer_req   = req_q;
  assign burst_done = bdone_q;
  assign xfer_count = cnt_q;

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done |=> xfer_req);

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_done |=> xfer_count == $past(xfer_count) + CNT_W'(1));

  a_r2_count_still: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_req && xfer_done) |=> $stable(xfer_count));

  a_r11_bdone_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> $past(xfer_done) && $past(xfer_req));

  a_r11_bdone_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  a_r9_paced: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_req) && $past(cfg_preq_en) |-> $past(preq));
endmodule

// File: tb/dma_trig_seq_tb.sv
`timescale 1ns/1ps
module dma_trig_seq_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_trig_en = 0, cfg_preq_en = 0, cfg_pol_hi = 1, cfg_level = 0, cfg_burst = 0;
  logic [3:0] cfg_bpow = 0;
  logic trig_in = 0, preq = 0, sw_start = 0, xfer_done = 0;
  logic xfer_req, burst_done;
  logic [15:0] xfer_count;

  int checks = 0, errors = 0, bd_cnt = 0, dbl_bd = 0, mover_delay = 0, wait_cnt = 0;
  logic mover_on = 1, prev_bd = 0, finished = 0;

  always #2 clk = ~clk;

  dma_trig_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_trig_en(cfg_trig_en), .cfg_preq_en(cfg_preq_en),
    .cfg_pol_hi(cfg_pol_hi), .cfg_level(cfg_level), .cfg_burst(cfg_burst),
    .cfg_bpow(cfg_bpow), .trig_in(trig_in), .preq(preq), .sw_start(sw_start),
    .xfer_req(xfer_req), .xfer_done(xfer_done), .burst_done(burst_done),
    .xfer_count(xfer_count));

  // {exp_bd, exp_cnt[10:0], bpow[3:0], burst, pol, trig_en}
  localparam logic [18:0] VEC [8] = '{
    {1'b1, 11'd1,    4'd0,  1'b0, 1'b1, 1'b1},
    {1'b1, 11'd1,    4'd0,  1'b0, 1'b0, 1'b1},
    {1'b1, 11'd1,    4'd0,  1'b1, 1'b1, 1'b1},
    {1'b1, 11'd8,    4'd3,  1'b1, 1'b1, 1'b1},
    {1'b1, 11'd32,   4'd5,  1'b1, 1'b0, 1'b1},
    {1'b1, 11'd1024, 4'd10, 1'b1, 1'b1, 1'b1},
    {1'b1, 11'd1024, 4'd15, 1'b1, 1'b0, 1'b1},
    {1'b0, 11'd0,    4'd3,  1'b1, 1'b1, 1'b0}
  };

  // data mover model and burst_done monitor
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (burst_done) bd_cnt++;
      if (burst_done && prev_bd) dbl_bd++;
    end
    prev_bd = burst_done;
    if (xfer_done) xfer_done = 0;
    else if (xfer_req && mover_on) begin
      if (wait_cnt >= mover_delay) begin xfer_done = 1; wait_cnt = 0; end
      else wait_cnt++;
    end else wait_cnt = 0;
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    cfg_trig_en = 0; cfg_preq_en = 0; cfg_level = 0; cfg_burst = 0; cfg_bpow = 0;
    cfg_pol_hi = 1; trig_in = 0; preq = 0; sw_start = 0;
    mover_on = 1; mover_delay = 0;
    cyc(4);
    rst_n = 1;
    cyc(1);
    bd_cnt = 0;
  endtask

  task automatic wait_quiet();
    int low = 0;
    for (int i = 0; i < 6000 && low < 12; i++) begin
      @(negedge clk);
      low = xfer_req ? 0 : low + 1;
    end
  endtask

  int base, bd_base;

  initial begin
    do_reset();
    check("R1 xfer_req after reset", int'(xfer_req), 0);
    check("R1 burst_done after reset", int'(burst_done), 0);
    check("R1 xfer_count after reset", int'(xfer_count), 0);

    // table: one trigger pulse per vector (R3 R4 R5 R7)
    for (int v = 0; v < 8; v++) begin
      logic rest;
      cfg_trig_en = 0;
      cfg_pol_hi = VEC[v][1]; cfg_burst = VEC[v][2]; cfg_bpow = VEC[v][6:3];
      rest = ~VEC[v][1];
      trig_in = rest;
      cyc(6);
      cfg_trig_en = VEC[v][0];
      cyc(2);
      base = int'(xfer_count); bd_base = bd_cnt;
      trig_in = ~rest; cyc(4); trig_in = rest;
      wait_quiet();
      check($sformatf("R3 R4 R5 R7 vector %0d count", v),
            int'(xfer_count) - base, int'(VEC[v][17:7]));
      check($sformatf("R11 vector %0d burst_done", v), bd_cnt - bd_base, int'(VEC[v][18]));
    end

    // R2: request held while mover stalls
    do_reset();
    mover_on = 0; cfg_trig_en = 1;
    trig_in = 1; cyc(30);
    check("R2 request held", int'(xfer_req), 1);
    check("R2 no count before done", int'(xfer_count), 0);
    mover_on = 1; wait_quiet();
    check("R2 count after done", int'(xfer_count), 1);

    // R5: opposite edge starts nothing
    trig_in = 0; wait_quiet();
    check("R5 falling edge ignored with rising polarity", int'(xfer_count), 1);
    cfg_pol_hi = 0; cyc(4);
    trig_in = 1; wait_quiet();
    check("R5 rising edge ignored with falling polarity", int'(xfer_count), 1);
    trig_in = 0; wait_quiet();
    check("R5 falling edge starts with falling polarity", int'(xfer_count), 2);

    // R6: level mode repeats, release at first burst_done -> exactly two runs
    do_reset();
    cfg_level = 1; cfg_burst = 1; cfg_bpow = 2; cfg_trig_en = 1;
    cyc(4);
    trig_in = 1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (burst_done) break;
    end
    trig_in = 0;
    wait_quiet();
    check("R6 level repeats count", int'(xfer_count), 8);
    check("R6 level repeats runs", bd_cnt, 2);

    // R8: edges during a run
    do_reset();
    cfg_burst = 1; cfg_bpow = 3; cfg_trig_en = 1; mover_delay = 3;
    cyc(4);
    for (int p = 0; p < 4; p++) begin
      trig_in = 1; cyc(4); trig_in = 0; cyc(4);
    end
    wait_quiet();
    check("R8 one pending run served", int'(xfer_count), 16);
    check("R8 runs", bd_cnt, 2);

    // R9: peripheral pacing
    do_reset();
    cfg_preq_en = 1; cfg_burst = 1; cfg_bpow = 1;
    cyc(10);
    check("R9 no request without preq", int'(xfer_req), 0);
    for (int p = 0; p < 3; p++) begin
      preq = 1; cyc(1); preq = 0; cyc(10);
    end
    check("R9 one transfer per preq", int'(xfer_count), 3);
    check("R9 burst_done after two", bd_cnt, 1);

    // R10: software start
    do_reset();
    cfg_burst = 1; cfg_bpow = 2;
    cyc(5);
    check("R10 idle before start", int'(xfer_req), 0);
    sw_start = 1; cyc(1); sw_start = 0;
    wait_quiet();
    check("R10 software start count", int'(xfer_count), 4);
    cfg_trig_en = 1; cyc(4);
    sw_start = 1; cyc(1); sw_start = 0;
    wait_quiet();
    check("R10 software start ignored with trigger enabled", int'(xfer_count), 4);

    check("R11 burst_done never doubled", dbl_bd, 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule